// File: doc/BRIEF.md
# Paged address translation table

This block turns a 32-bit local memory-mapped address into a 64-bit bus address. The low offset bits of the request go through untouched. A small page-select field just above the offset picks one entry of a page table, and that entry supplies every translated bit above the offset. Each entry also carries a size attribute. A narrow entry yields a 32-bit address, with the upper half forced to zero. A wide entry yields the full 64-bit value. Address bits above the page-select field belong to upstream slave decoding, and the translator ignores them.

Translation is registered through one output slot with a valid/ready handshake. The slot state machine has two states, `ST_EMPTY` and `ST_FULL`:
- `ST_EMPTY` moves to `ST_FULL` when a request is accepted.
- `ST_FULL` stays in `ST_FULL` when the result drains and a new request is accepted in the same cycle.
- `ST_FULL` returns to `ST_EMPTY` when the result drains and no request arrives.

A parameter chooses how the table is held:
- **Run-time table:** flops that a simple register port can write and read. Its read side is a second machine with two states. `RP_IDLE` moves to `RP_DATA` on a read. `RP_DATA` stays in `RP_DATA` when reads arrive back to back, and returns to `RP_IDLE` otherwise.
- **Fixed table:** computed at elaboration. Entry k holds a base value plus k.

Top module: `page_xlat_top`

## Requirements
- R1: After reset, `out_valid` and `reg_rvalid` are 0 and `in_ready` is 1. Every run-time entry is zero and narrow, so a translation returns only the offset, with `out_wide` = 0.
- R2: Translated bits [19:0] equal request bits [19:0].
- R3: Request bits [23:20] select the table entry used for translation.
- R4: Request bits [31:24] have no effect on the translated address or on `out_wide`.
- R5: For a wide entry (size bit = 1), translated bits [63:20] equal the entry's 44 stored upper bits and `out_wide` = 1.
- R6: For a narrow entry (size bit = 0), translated bits [63:32] are zero, bits [31:20] come from the entry, and `out_wide` = 0.
- R7: Entry k occupies two register indices:
  - Index 2k, low word: bits [31:20] hold translated bits [31:20], bit 0 holds the size (1 = 64-bit), and bits [19:1] read as zero.
  - Index 2k+1, high word: holds translated bits [63:32].
- R8: A read at index i raises `reg_rvalid` in the next cycle, with `reg_rdata` holding the word at i.
- R9: The register index is 6 bits wide. Indices 32 to 63 are unimplemented: they read as zero, and writes to them change no entry.
- R10: A request accepted at a clock edge (`in_valid` and `in_ready`) appears on `out_valid`/`out_addr` right after that edge. `in_ready` is 0 while a result is held and `out_ready` is 0.
- R11: While `out_valid` = 1 and `out_ready` = 0, `out_addr` and `out_wide` stay unchanged.
- R12: A table write changes translations only for requests accepted at a later clock edge. A request accepted at the same edge as the write uses the old entry.
- R13: With the fixed table (DYNAMIC = 0), entry k's upper bits are FIXED_BASE + k and its size comes from FIXED_WIDE. Register writes have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 32 | Local address |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 64 | Translated address |
| out_wide | output | 1 | 1 = 64-bit result, 0 = 32-bit result |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 6 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |

## Verification
The bench targets the following corner cases and the wrong behaviour each would expose:
- **Write and request at the same edge.** A table that forwards write data into the lookup would return the new entry one request early.
- **Stall.** A slot that reloaded while stalled would drop the held result or change it.
- **Decode slicing.** Requests that differ only in their top byte must translate alike. A decoder sliced one bit too wide would select the wrong page.
- **Unimplemented register indices.** A decoder that wrapped the index would let these writes corrupt page 0.
- **Narrow entries.** Stale high-word contents must not leak into bits [63:32].
- **Fixed table.** Writes must not alter it.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_t;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_DATA = 1'b1
    } rport_state_t;

endpackage

// File: rtl/pxl_table.sv
module pxl_table #(
    parameter int          OFS_W      = 20,
    parameter int          PG_W       = 4,
    parameter int          OUT_AW     = 64,
    parameter int          REG_AW     = 6,
    parameter bit          DYNAMIC    = 1'b1,
    parameter logic [43:0] FIXED_BASE = '0,
    parameter bit          FIXED_WIDE = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        acc_idx,
    input  logic [31:0]              wr_data,
    output logic [31:0]              rd_word,
    input  logic [PG_W-1:0]          lk_page,
    output logic [OUT_AW-OFS_W-1:0]  lk_upper,
    output logic                     lk_wide
);
    localparam int NUM_PG = 1 << PG_W;
    localparam int UPW    = OUT_AW - OFS_W;
    localparam int LO_UP  = 32 - OFS_W;

    logic [UPW-1:0]  ent_up   [NUM_PG];
    logic            ent_wide [NUM_PG];
    logic            idx_hit;
    logic [PG_W-1:0] idx_pg;
    logic            idx_hi;

    assign idx_hit = ~|acc_idx[REG_AW-1:PG_W+1];
    assign idx_pg  = acc_idx[PG_W:1];
    assign idx_hi  = acc_idx[0];

    generate
        if (DYNAMIC) begin : g_dyn
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < NUM_PG; k++) begin
                        ent_up[k]   <= '0;
                        ent_wide[k] <= 1'b0;
                    end
                end else if (wr_en && idx_hit) begin
                    if (!idx_hi) begin
                        ent_up[idx_pg][LO_UP-1:0] <= wr_data[31:OFS_W];
                        ent_wide[idx_pg]          <= wr_data[0];
                    end else begin
                        ent_up[idx_pg][UPW-1:LO_UP] <= wr_data;
                    end
                end
            end
        end else begin : g_fix
            for (genvar g = 0; g < NUM_PG; g++) begin : g_ent
                assign ent_up[g]   = FIXED_BASE[UPW-1:0] + UPW'(g);
                assign ent_wide[g] = FIXED_WIDE;
            end
        end
    endgenerate

    always_comb begin
        if (!idx_hit) begin
            rd_word = '0;
        end else if (!idx_hi) begin
            rd_word = {ent_up[idx_pg][LO_UP-1:0], {(OFS_W-1){1'b0}}, ent_wide[idx_pg]};
        end else begin
            rd_word = ent_up[idx_pg][UPW-1:LO_UP];
        end
    end

    assign lk_upper = ent_up[lk_page];
    assign lk_wide  = ent_wide[lk_page];

endmodule

// File: rtl/pxl_regport.sv
module pxl_regport (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [31:0] word_in,
    output logic        rvalid,
    output logic [31:0] rdata
);
    import pxl_pkg::*;

    rport_state_t state_q, state_d;
    logic [31:0]  data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (rd_en)  state_d = RP_DATA;
            RP_DATA: if (!rd_en) state_d = RP_IDLE;
            default: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) data_q <= word_in;
        end
    end

    always_comb begin
        rvalid = (state_q == RP_DATA);
        rdata  = data_q;
    end

endmodule

// File: rtl/pxl_slot.sv
module pxl_slot #(
    parameter int OUT_AW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OUT_AW-1:0] in_xaddr,
    input  logic              in_wide,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_AW-1:0] out_addr,
    output logic              out_wide
);
    import pxl_pkg::*;

    slot_state_t       state_q, state_d;
    logic [OUT_AW-1:0] addr_q;
    logic              wide_q;
    logic              take;

    assign take = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            addr_q  <= '0;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                addr_q <= in_xaddr;
                wide_q <= in_wide;
            end
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        out_addr  = addr_q;
        out_wide  = wide_q;
    end

endmodule

// File: rtl/page_xlat_top.sv
module page_xlat_top #(
    parameter int          IN_AW      = 32,
    parameter int          OFS_W      = 20,
    parameter int          PG_W       = 4,
    parameter int          OUT_AW     = 64,
    parameter int          REG_AW     = PG_W + 2,
    parameter bit          DYNAMIC    = 1'b1,
    parameter logic [43:0] FIXED_BASE = '0,
    parameter bit          FIXED_WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_AW-1:0]  in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_AW-1:0] out_addr,
    output logic              out_wide,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic              reg_rvalid,
    output logic [31:0]       reg_rdata
);
    localparam int UPW = OUT_AW - OFS_W;

    logic [UPW-1:0]    lk_upper;
    logic              lk_wide;
    logic [31:0]       rd_word;
    logic [OUT_AW-1:0] xaddr;

    pxl_table #(
        .OFS_W(OFS_W), .PG_W(PG_W), .OUT_AW(OUT_AW), .REG_AW(REG_AW),
        .DYNAMIC(DYNAMIC), .FIXED_BASE(FIXED_BASE), .FIXED_WIDE(FIXED_WIDE)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .acc_idx(reg_idx), .wr_data(reg_wdata),
        .rd_word(rd_word),
        .lk_page(in_addr[OFS_W+PG_W-1:OFS_W]),
        .lk_upper(lk_upper), .lk_wide(lk_wide)
    );

    always_comb begin
        xaddr = {lk_upper, in_addr[OFS_W-1:0]};
        if (!lk_wide) xaddr[OUT_AW-1:32] = '0;
    end

    pxl_slot #(.OUT_AW(OUT_AW)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_xaddr(xaddr), .in_wide(lk_wide),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_wide(out_wide)
    );

    pxl_regport u_rport (
        .clk(clk), .rst_n(rst_n),
        .rd_en(reg_rd), .word_in(rd_word),
        .rvalid(reg_rvalid), .rdata(reg_rdata)
    );

endmodule

// File: rtl/pxl_checker.sv
module pxl_checker #(
    parameter int IN_AW  = 32,
    parameter int OFS_W  = 20,
    parameter int OUT_AW = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [IN_AW-1:0]  in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_AW-1:0] out_addr,
    input logic              out_wide,
    input logic              reg_rd,
    input logic              reg_rvalid
);
    p_accept_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_addr[OFS_W-1:0] == $past(in_addr[OFS_W-1:0])));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_wide)));

    p_narrow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_addr[OUT_AW-1:32] == '0));

    p_read_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    p_no_spur_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

endmodule

bind page_xlat_top pxl_checker #(.IN_AW(IN_AW), .OFS_W(OFS_W), .OUT_AW(OUT_AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_wide(out_wide),
    .reg_rd(reg_rd), .reg_rvalid(reg_rvalid)
);

// File: tb/page_xlat_top_test.sv
module page_xlat_top_test;
    localparam logic [43:0] FBASE = 44'h000_1111_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_ready = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;

    logic        in_ready, out_valid, out_wide, reg_rvalid;
    logic [63:0] out_addr;
    logic [31:0] reg_rdata;
    logic        f_in_ready, f_out_valid, f_out_wide, f_rvalid;
    logic [63:0] f_out_addr;
    logic [31:0] f_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    page_xlat_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_wide(out_wide), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata)
    );

    page_xlat_top #(.DYNAMIC(1'b0), .FIXED_BASE(FBASE), .FIXED_WIDE(1'b1)) uut_fixed (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_in_ready),
        .in_addr(in_addr), .out_valid(f_out_valid), .out_ready(out_ready),
        .out_addr(f_out_addr), .out_wide(f_out_wide), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rvalid(f_rvalid),
        .reg_rdata(f_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(reg_rvalid == 1'b1, {tag, " rvalid"}, 64'(reg_rvalid), 64'd1);
        chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic xlat(input logic [31:0] a, input logic [63:0] exp, input bit expw,
                        input string tag);
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
        chk(out_addr == exp, tag, out_addr, exp);
        chk(out_wide == expw, {tag, " wide"}, 64'(out_wide), 64'(expw));
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(reg_rvalid == 1'b0, "R1 rvalid", 64'(reg_rvalid), 64'd0);
        xlat(32'h0098_7654, 64'h0000_0000_0008_7654, 1'b0, "R1 zero entry");
    endtask

    task automatic t_wide();
        reg_write(6'd6, 32'hABC0_0001);
        reg_write(6'd7, 32'h1234_5678);
        xlat(32'h0031_2345, 64'h1234_5678_ABC1_2345, 1'b1, "R5 R2 R3 wide page3");
        xlat(32'hFF31_2345, 64'h1234_5678_ABC1_2345, 1'b1, "R4 top byte ignored");
        xlat(32'h5A3F_FFFF, 64'h1234_5678_ABCF_FFFF, 1'b1, "R4 R2 max offset");
    endtask

    task automatic t_narrow();
        reg_write(6'd15, 32'h9999_9999);
        reg_write(6'd14, 32'h5550_FFFE);
        xlat(32'h0075_4321, 64'h0000_0000_5555_4321, 1'b0, "R6 narrow page7");
        xlat(32'h0035_4321, 64'h1234_5678_ABC5_4321, 1'b1, "R3 other page unchanged");
    endtask

    task automatic t_regs();
        reg_read(6'd6, 32'hABC0_0001, "R7 R8 low word");
        reg_read(6'd7, 32'h1234_5678, "R7 R8 high word");
        reg_read(6'd14, 32'h5550_0000, "R7 reserved bits zero");
    endtask

    task automatic t_unimpl();
        reg_write(6'd40, 32'hFFFF_FFFF);
        reg_write(6'd32, 32'hFFFF_FFFF);
        reg_read(6'd40, 32'h0, "R9 unimplemented read");
        reg_read(6'd0, 32'h0, "R9 page0 untouched");
        xlat(32'h000A_BCDE, 64'h0000_0000_000A_BCDE, 1'b0, "R9 page0 translate");
    endtask

    task automatic t_same_edge();
        @(negedge clk);
        out_ready = 1'b1;
        reg_wr = 1'b1; reg_idx = 6'd10; reg_wdata = 32'h7770_0000;
        in_valid = 1'b1; in_addr = 32'h0051_1111;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(out_addr == 64'h0000_0000_0001_1111, "R12 old entry same edge",
            out_addr, 64'h0000_0000_0001_1111);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_addr == 64'h0000_0000_7771_1111, "R12 new entry next edge",
            out_addr, 64'h0000_0000_7771_1111);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0030_0001;
        @(negedge clk);
        in_addr = 32'h0050_0002;
        chk(out_valid == 1'b1, "R10 latency", 64'(out_valid), 64'd1);
        chk(in_ready == 1'b0, "R10 ready low when full", 64'(in_ready), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk(out_addr == 64'h1234_5678_ABC0_0001, "R11 held under stall",
            out_addr, 64'h1234_5678_ABC0_0001);
        chk(out_wide == 1'b1, "R11 wide held", 64'(out_wide), 64'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_addr == 64'h0000_0000_7770_0002, "R10 next after drain",
            out_addr, 64'h0000_0000_7770_0002);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 slot empties", 64'(out_valid), 64'd0);
    endtask

    task automatic t_fixed();
        logic [63:0] e;
        e = {FBASE + 44'd2, 20'h12345};
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b1; in_addr = 32'hC021_2345;
        @(negedge clk);
        in_valid = 1'b0;
        chk(f_out_valid == 1'b1, "R13 fixed valid", 64'(f_out_valid), 64'd1);
        chk(f_out_addr == e, "R13 fixed entry despite writes", f_out_addr, e);
        chk(f_out_wide == 1'b1, "R13 fixed wide", 64'(f_out_wide), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        reg_write(6'd4, 32'hFFF0_0000);
        reg_write(6'd5, 32'hFFFF_FFFF);
        t_wide();
        t_narrow();
        t_regs();
        t_unimpl();
        t_same_edge();
        t_stall();
        t_fixed();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule